// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit successive-approximation converter. A one-cycle start pulse, qualified by a 4-bit address, begins a conversion. The sequencer then puts a trial code on its output for an external DAC and comparator. Each step it reads back one comparator decision and settles one bit of the code, starting at the most significant bit. When the last bit is settled, a single latch cycle copies the finished code into the result register and the end-of-conversion flag goes high again.

The address selects one of eleven external channels, one of three internal self-test levels, or power-down. On a self-test address the external comparator is ignored. An internal ideal comparator against a fixed level (half scale, zero or full scale) is used instead, so the usual step sequence yields exact known codes. The power-down address starts no conversion and raises a status output. An abort input discards a conversion that is still in its step phase. An internal divider sets how many clock cycles each step lasts.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, eocFlag is 1, resultCode is 0, trialCode is 0 and powerDown is 0.
- R2: One clock after a start is accepted, trialCode is 0x800. Each step lasts CONV_DIV clocks, and the step after a kept MSB shows 0xC00.
- R3: The external comparator input cmpAbove means "input at or above the present trial code". At each step's decision the trial bit is kept when cmpAbove is 1 and cleared when it is 0. For an in-range input level L, the final code is L.
- R4: A start is accepted only while idle. eocFlag goes low on the clock edge that accepts the start. It stays low for exactly RES_BITS*CONV_DIV+1 clocks. It rises on the same edge that loads resultCode with the finished code.
- R5: Addresses 0xB, 0xC and 0xD produce 0x800, 0x000 and 0xFFF respectively, whatever cmpAbove does.
- R6: Addresses 0x0 through 0xA run a conversion driven by cmpAbove.
- R7: A comparator that is always 1 (input above the upper reference) gives 0xFFF. A comparator that is always 0 (input below the lower reference) gives 0x000.
- R8: Address 0xE starts no conversion. eocFlag stays 1, resultCode is unchanged, and powerDown goes to 1. powerDown stays 1 until a start with a converting address (0x0 to 0xD) is accepted, which clears it on that edge.
- R9: abortIn held high on a clock edge during the step phase ends the conversion. eocFlag is 1 on the next clock and resultCode keeps its previous value.
- R10: A start pulse during a conversion is ignored. The running conversion keeps its timing and result.
- R11: Address 0xF is reserved. A start with it changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request to begin, qualified by addrIn |
| addrIn | input | 4 | Channel, self-test or power-down address |
| abortIn | input | 1 | Discards a conversion still in its step phase |
| cmpAbove | input | 1 | Comparator decision: input at or above trialCode |
| trialCode | output | RES_BITS | Code presented to the external DAC |
| resultCode | output | RES_BITS | Last completed conversion result |
| eocFlag | output | 1 | High when idle, low while converting |
| powerDown | output | 1 | Power-down address has been accepted |

## Verification
On every cycle, the assertions check four things:
- eocFlag only falls in the cycle after an accepted start.
- resultCode only changes when eocFlag rises.
- powerDown never coexists with a running conversion.
- The trial code changes by at most one clear and one set per clock.

Only the directed scenarios can show the following: the exact codes produced for each input level and for the self-test addresses, the exact conversion latency, the MSB-first trial sequence, and that aborts, busy starts and the reserved address leave the previous result in place.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    KIND_EXT  = 2'd0,
    KIND_TEST = 2'd1,
    KIND_PD   = 2'd2,
    KIND_RSVD = 2'd3
  } addrKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic startConv;  // load MSB trial, capture test selection
    logic decide;     // resolve current bit, try next one
    logic latch;      // copy finished code to result register
  } seqStrobe_t;

  localparam logic [3:0] ADDR_LAST_EXT = 4'hA;
  localparam logic [3:0] ADDR_TEST_MID = 4'hB;
  localparam logic [3:0] ADDR_TEST_LO  = 4'hC;
  localparam logic [3:0] ADDR_TEST_HI  = 4'hD;
  localparam logic [3:0] ADDR_PWR_DN   = 4'hE;

  function automatic addrKind_e decodeAddr(input logic [3:0] a);
    if (a <= ADDR_LAST_EXT)    return KIND_EXT;
    else if (a <= ADDR_TEST_HI) return KIND_TEST;
    else if (a == ADDR_PWR_DN)  return KIND_PD;
    else                        return KIND_RSVD;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int STEPS    = 12,
  parameter int CONV_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [3:0] addrIn,
  input  logic       abortIn,
  output seqStrobe_t strobe,
  output logic       eocFlag,
  output logic       powerDown
);

  localparam int DIV_W  = (CONV_DIV > 1) ? $clog2(CONV_DIV) : 1;
  localparam int STEP_W = $clog2(STEPS + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CONV_DIV - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_LATCH} state_e;

  state_e            state;
  logic [DIV_W-1:0]  divCnt;
  logic [STEP_W-1:0] stepCnt;
  addrKind_e         kind;
  logic              acceptStart;
  logic              divWrap;

  always_comb begin
    kind             = decodeAddr(addrIn);
    acceptStart      = (state == ST_IDLE) && startPulse;
    divWrap          = (divCnt == DIV_LAST);
    strobe.startConv = acceptStart && ((kind == KIND_EXT) || (kind == KIND_TEST));
    strobe.decide    = (state == ST_CONV) && !abortIn && divWrap;
    strobe.latch     = (state == ST_LATCH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      stepCnt   <= '0;
      eocFlag   <= 1'b1;
      powerDown <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strobe.startConv) begin
            state     <= ST_CONV;
            eocFlag   <= 1'b0;
            powerDown <= 1'b0;
            divCnt    <= '0;
            stepCnt   <= '0;
          end else if (acceptStart && (kind == KIND_PD)) begin
            powerDown <= 1'b1;
          end
        end
        ST_CONV: begin
          if (abortIn) begin
            state   <= ST_IDLE;
            eocFlag <= 1'b1;
          end else if (divWrap) begin
            divCnt <= '0;
            if (stepCnt == STEP_LAST) state <= ST_LATCH;
            else                      stepCnt <= stepCnt + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_LATCH: begin
          state   <= ST_IDLE;
          eocFlag <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [3:0]          addrIn,
  input  logic                cmpAbove,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultCode
);

  localparam logic [RES_BITS-1:0] MSB_ONE   = {1'b1, {(RES_BITS-1){1'b0}}};
  localparam logic [RES_BITS-1:0] LEVEL_LO  = '0;
  localparam logic [RES_BITS-1:0] LEVEL_HI  = '1;
  localparam logic [RES_BITS-1:0] LEVEL_MID = MSB_ONE;

  logic [RES_BITS-1:0] sarReg;
  logic [RES_BITS-1:0] bitMask;
  logic [RES_BITS-1:0] fixedLevel;
  logic [RES_BITS-1:0] resultReg;
  logic                useFixed;

  logic                decision;
  logic [RES_BITS-1:0] keptCode;
  logic [RES_BITS-1:0] nextMask;
  logic [RES_BITS-1:0] levelSel;

  always_comb begin
    case (addrIn)
      ADDR_TEST_MID: levelSel = LEVEL_MID;
      ADDR_TEST_HI:  levelSel = LEVEL_HI;
      default:       levelSel = LEVEL_LO;
    endcase
    // internal ideal comparator for self-test levels
    decision = useFixed ? (fixedLevel >= sarReg) : cmpAbove;
    keptCode = decision ? sarReg : (sarReg & ~bitMask);
    nextMask = bitMask >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg     <= '0;
      bitMask    <= '0;
      fixedLevel <= '0;
      useFixed   <= 1'b0;
      resultReg  <= '0;
    end else begin
      if (strobe.startConv) begin
        sarReg     <= MSB_ONE;
        bitMask    <= MSB_ONE;
        useFixed   <= (decodeAddr(addrIn) == KIND_TEST);
        fixedLevel <= levelSel;
      end else if (strobe.decide) begin
        sarReg  <= keptCode | nextMask;
        bitMask <= nextMask;
      end
      if (strobe.latch) resultReg <= sarReg;
    end
  end

  assign trialCode  = sarReg;
  assign resultCode = resultReg;

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int CONV_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [3:0]          addrIn,
  input  logic                abortIn,
  input  logic                cmpAbove,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultCode,
  output logic                eocFlag,
  output logic                powerDown
);

  seqStrobe_t strobe;

  sar_seq_ctrl #(.STEPS(RES_BITS), .CONV_DIV(CONV_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .addrIn(addrIn),
    .abortIn(abortIn), .strobe(strobe), .eocFlag(eocFlag), .powerDown(powerDown)
  );

  sar_seq_dp #(.RES_BITS(RES_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn),
    .cmpAbove(cmpAbove), .trialCode(trialCode), .resultCode(resultCode)
  );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                startPulse,
  input logic [RES_BITS-1:0] trialCode,
  input logic [RES_BITS-1:0] resultCode,
  input logic                eocFlag,
  input logic                powerDown
);

  // R4
  eoc_fall_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocFlag) |-> $past(startPulse));

  // R9
  result_at_eoc_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(resultCode) |-> $rose(eocFlag));

  // R8
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> eocFlag);

  // R2
  trial_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eocFlag && $past(!eocFlag)) |-> ($countones(trialCode ^ $past(trialCode)) <= 2));

endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .trialCode(trialCode),
  .resultCode(resultCode), .eocFlag(eocFlag), .powerDown(powerDown)
);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;

  localparam int RES = 12;
  localparam int DIV = 4;
  localparam int LAT = RES * DIV + 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startPulse = 1'b0;
  logic [3:0]     addrIn = 4'h0;
  logic           abortIn = 1'b0;
  logic           cmpAbove;
  logic [RES-1:0] trialCode;
  logic [RES-1:0] resultCode;
  logic           eocFlag;
  logic           powerDown;

  int level = 0;
  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  // comparator model: input at or above trial code
  always_comb cmpAbove = (level >= int'(trialCode));

  sar_seq_top #(.RES_BITS(RES), .CONV_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .addrIn(addrIn),
    .abortIn(abortIn), .cmpAbove(cmpAbove), .trialCode(trialCode),
    .resultCode(resultCode), .eocFlag(eocFlag), .powerDown(powerDown)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic pulseStart(input logic [3:0] a);
    startPulse = 1'b1;
    addrIn = a;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitEoc(output int cnt);
    cnt = 0;
    while (!eocFlag && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic runConv(input logic [3:0] a, input int lvl, input int exp, input string req);
    int cnt;
    level = lvl;
    pulseStart(a);
    chk("R4 eoc low after start", int'(eocFlag), 0);
    waitEoc(cnt);
    chk("R4 latency", cnt, LAT);
    chk(req, int'(resultCode), exp);
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 eoc", int'(eocFlag), 1);
    chk("R1 result", int'(resultCode), 0);
    chk("R1 trial", int'(trialCode), 0);
    chk("R1 powerDown", int'(powerDown), 0);
  endtask

  task automatic testStepOrder();
    int cnt;
    level = 'hFFF;
    pulseStart(4'h5);
    chk("R2 first trial", int'(trialCode), 'h800);
    repeat (DIV - 1) @(negedge clk);
    chk("R2 trial held for step", int'(trialCode), 'h800);
    @(negedge clk);
    chk("R2 second trial kept MSB", int'(trialCode), 'hC00);
    waitEoc(cnt);
    chk("R3 full code", int'(resultCode), 'hFFF);
    @(negedge clk);
    level = 'h400;
    pulseStart(4'h5);
    repeat (DIV) @(negedge clk);
    chk("R3 MSB cleared", int'(trialCode), 'h400);
    waitEoc(cnt);
    chk("R3 code 0x400", int'(resultCode), 'h400);
    @(negedge clk);
  endtask

  task automatic testChannels();
    runConv(4'h0, 'h123, 'h123, "R6 channel 0");
    runConv(4'h7, 'hABC, 'hABC, "R6 channel 7");
    runConv(4'hA, 'h001, 'h001, "R6 channel 10");
    runConv(4'h3, 'h800, 'h800, "R3 exact midscale");
  endtask

  task automatic testClamp();
    runConv(4'h1, 5000, 'hFFF, "R7 above upper reference");
    runConv(4'h2, -5, 'h000, "R7 below lower reference");
  endtask

  task automatic testSelfTest();
    runConv(4'hB, -5, 'h800, "R5 mid test");
    runConv(4'hC, 5000, 'h000, "R5 low test");
    runConv(4'hD, -5, 'hFFF, "R5 high test");
  endtask

  task automatic testAbort();
    level = 'h321;
    pulseStart(4'h4);
    repeat (10) @(negedge clk);
    abortIn = 1'b1;
    @(negedge clk);
    abortIn = 1'b0;
    chk("R9 eoc high after abort", int'(eocFlag), 1);
    chk("R9 result kept", int'(resultCode), 'hFFF);
    repeat (LAT) @(negedge clk);
    chk("R9 result still kept", int'(resultCode), 'hFFF);
    runConv(4'h4, 'h321, 'h321, "R9 conversion after abort");
  endtask

  task automatic testBusyStart();
    int c2;
    level = 'h5A5;
    pulseStart(4'h3);
    repeat (4) @(negedge clk);
    pulseStart(4'hD);
    waitEoc(c2);
    chk("R10 latency unchanged", 5 + c2, LAT);
    chk("R10 result from first start", int'(resultCode), 'h5A5);
    @(negedge clk);
  endtask

  task automatic testPowerDown();
    int cnt;
    pulseStart(4'hE);
    chk("R8 eoc stays high", int'(eocFlag), 1);
    chk("R8 powerDown set", int'(powerDown), 1);
    repeat (LAT) @(negedge clk);
    chk("R8 eoc still high", int'(eocFlag), 1);
    chk("R8 result unchanged", int'(resultCode), 'h5A5);
    pulseStart(4'hF);
    chk("R11 powerDown unchanged", int'(powerDown), 1);
    chk("R11 eoc high", int'(eocFlag), 1);
    repeat (LAT) @(negedge clk);
    chk("R11 result unchanged", int'(resultCode), 'h5A5);
    level = 'h0F0;
    pulseStart(4'h6);
    chk("R8 powerDown cleared by start", int'(powerDown), 0);
    waitEoc(cnt);
    chk("R8 conversion after power-down", int'(resultCode), 'h0F0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R4 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStepOrder();
    testChannels();
    testClamp();
    testSelfTest();
    testAbort();
    testBusyStart();
    testPowerDown();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule